// File: doc/BRIEF.md
# Rotated Immediate Constant Expander

This block turns a compact immediate field into a full 32-bit operand, and also performs the inverse: it takes a 32-bit constant and searches for a field that reproduces it. The field carries an 8-bit payload, a 4-bit rotate count and a 2-bit form selector. In the plain rotate mode the payload is rotated right by an even number of positions. The extended mode adds three byte-replication forms on top of the rotate form.

Requests enter through a valid/ready handshake together with an operation select (expand or encode) and a mode select (plain or extended). Each accepted request produces one response from a single register stage, with the response valid one cycle after acceptance. An encode request for a value that no field can produce returns an invalid flag instead of a field. An expand request also returns a shifter carry. The carry follows the top result bit when a rotation took place, and passes the incoming carry through otherwise.

Top module: `imm_const_unit`

## Requirements
- R1: Field layout: bits [7:0] are the payload, [11:8] the rotate count, [13:12] the form. With `mode_i`=0 (plain) and `op_i`=0 (expand), the result is the zero-extended payload rotated right by twice the rotate count, and the form bits are ignored (payload 0x23 with count 4 gives 0x23000000).
- R2: With `mode_i`=1 (extended) and form 0, expansion is identical to R1.
- R3: In extended mode, form 1 gives 0x00XY00XY, form 2 gives 0xXY00XY00 and form 3 gives 0xXYXYXYXY, where XY is the payload and the rotate count is ignored.
- R4: For an expand, `rsp_carry_o` equals result bit 31 when the rotate form is used with a non-zero count. In every other case it equals `carry_i` as sampled at acceptance.
- R5: With `op_i`=1 (encode) in plain mode, the returned field has form 0 and uses the smallest rotate count whose expansion equals `value_i`.
- R6: In extended mode, encode prefers the rotate form (smallest count). Failing that it tries form 1, then form 2, then form 3, with the rotate count set to 0.
- R7: An encode with no matching field sets `rsp_invalid_o` and returns an all-zero field (0x3FF is invalid in both modes; 0xA5A5A5A5 is invalid in plain mode).
- R8: A request is accepted when `req_valid_i` and `req_ready_o` are both high. `rsp_valid_o` rises on the next cycle. `req_ready_o` is high whenever no response is pending or `rsp_ready_i` is high. A pending, unaccepted response holds all of its outputs stable.
- R9: During and right after reset, `rsp_valid_o` is 0 and `req_ready_o` is 1.
- R10: An expand response has `rsp_field_o`=0 and `rsp_invalid_o`=0. An encode response has `rsp_value_o`=0 and `rsp_carry_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| op_i | input | 1 | 0 expand, 1 encode |
| mode_i | input | 1 | 0 plain rotate, 1 extended |
| field_i | input | 14 | Immediate field for expand |
| value_i | input | 32 | Constant for encode |
| carry_i | input | 1 | Incoming carry for expand |
| rsp_valid_o | output | 1 | Response present |
| rsp_ready_i | input | 1 | Response consumed this cycle |
| rsp_value_o | output | 32 | Expanded operand |
| rsp_carry_o | output | 1 | Shifter carry of the expansion |
| rsp_field_o | output | 14 | Field found by encode |
| rsp_invalid_o | output | 1 | Encode found no field |

## Verification
A corrupted rotate amount or a wrong form decode shows in the value of the very next response. A wrong priority in the encoder search shows as a larger rotate count than the smallest legal one. The bench catches this by sweeping a payload whose encoding is unique across all sixteen rotations and by probing constants that have several encodings. A fault in the response register shows within one stalled cycle: outputs change while `rsp_ready_i` is low, or a queued request overwrites the pending one.

// File: rtl/imm_pkg.sv
package imm_pkg;
  typedef enum logic {OP_EXPAND = 1'b0, OP_ENCODE = 1'b1} op_e;
  typedef enum logic {MODE_ROT = 1'b0, MODE_EXT = 1'b1} mode_e;
  typedef enum logic [1:0] {
    KIND_ROT = 2'd0,
    KIND_LO  = 2'd1,
    KIND_HI  = 2'd2,
    KIND_ALL = 2'd3
  } kind_e;
endpackage

// File: rtl/imm_pattern.sv
module imm_pattern #(
  parameter int DATA_W  = 32,
  parameter int CONST_W = 8
) (
  input  logic [CONST_W-1:0]  byte_i,
  input  imm_pkg::kind_e      kind_i,
  output logic [DATA_W-1:0]   pat_o
);
  localparam int LANE_W = 2 * CONST_W;
  localparam int LANES  = DATA_W / LANE_W;

  logic [DATA_W-1:0] lo_w, hi_w, all_w;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lo_w[g*LANE_W +: LANE_W]  = {{CONST_W{1'b0}}, byte_i};
    assign hi_w[g*LANE_W +: LANE_W]  = {byte_i, {CONST_W{1'b0}}};
    assign all_w[g*LANE_W +: LANE_W] = {byte_i, byte_i};
  end

  always_comb begin
    unique case (kind_i)
      imm_pkg::KIND_LO:  pat_o = lo_w;
      imm_pkg::KIND_HI:  pat_o = hi_w;
      imm_pkg::KIND_ALL: pat_o = all_w;
      default:           pat_o = '0;
    endcase
  end
endmodule

// File: rtl/imm_expand.sv
module imm_expand #(
  parameter int DATA_W  = 32,
  parameter int CONST_W = 8,
  parameter int ROT_W   = 4,
  localparam int FIELD_W = CONST_W + ROT_W + 2
) (
  input  imm_pkg::mode_e      mode_i,
  input  logic [FIELD_W-1:0]  field_i,
  input  logic                carry_i,
  output logic [DATA_W-1:0]   value_o,
  output logic                carry_o
);
  localparam int AMT_W = ROT_W + 1;

  logic [CONST_W-1:0]  imm;
  logic [ROT_W-1:0]    rot;
  imm_pkg::kind_e      kind;
  logic [AMT_W-1:0]    amt;
  logic [DATA_W-1:0]   zext;
  logic [2*DATA_W-1:0] dbl;
  logic [DATA_W-1:0]   pat;
  logic                use_rot;

  assign imm  = field_i[CONST_W-1:0];
  assign rot  = field_i[CONST_W +: ROT_W];
  assign kind = imm_pkg::kind_e'(field_i[FIELD_W-1 -: 2]);
  assign amt  = {rot, 1'b0};
  assign zext = {{(DATA_W-CONST_W){1'b0}}, imm};
  assign dbl  = {zext, zext} >> amt;

  imm_pattern #(.DATA_W(DATA_W), .CONST_W(CONST_W)) u_pat (
    .byte_i (imm),
    .kind_i (kind),
    .pat_o  (pat)
  );

  // plain mode ignores the form bits
  assign use_rot = (mode_i == imm_pkg::MODE_ROT) || (kind == imm_pkg::KIND_ROT);

  always_comb begin
    if (use_rot) value_o = dbl[DATA_W-1:0];
    else         value_o = pat;
    carry_o = (use_rot && (rot != '0)) ? value_o[DATA_W-1] : carry_i;
  end
endmodule

// File: rtl/imm_encode.sv
module imm_encode #(
  parameter int DATA_W  = 32,
  parameter int CONST_W = 8,
  parameter int ROT_W   = 4,
  localparam int FIELD_W = CONST_W + ROT_W + 2
) (
  input  imm_pkg::mode_e      mode_i,
  input  logic [DATA_W-1:0]   value_i,
  output logic [FIELD_W-1:0]  field_o,
  output logic                invalid_o
);
  localparam int ROT_N = 1 << ROT_W;

  logic [ROT_N-1:0]   hit;
  logic [CONST_W-1:0] cand [ROT_N];
  logic [ROT_W-1:0]   rot_sel;
  logic               rot_found;
  logic [CONST_W-1:0] byte_lo, byte_hi;
  logic [DATA_W-1:0]  pat_lo, pat_hi, pat_all;

  // one rotate-left probe per candidate count
  for (genvar r = 0; r < ROT_N; r++) begin : g_rot
    localparam int SH = 2 * r;
    logic [2*DATA_W-1:0] wide;
    assign wide    = {value_i, value_i} >> (DATA_W - SH);
    assign hit[r]  = (wide[DATA_W-1:CONST_W] == '0);
    assign cand[r] = wide[CONST_W-1:0];
  end

  // lowest count wins
  always_comb begin
    rot_sel   = '0;
    rot_found = 1'b0;
    for (int r = ROT_N - 1; r >= 0; r--) begin
      if (hit[r]) begin
        rot_found = 1'b1;
        rot_sel   = ROT_W'(r);
      end
    end
  end

  assign byte_lo = value_i[CONST_W-1:0];
  assign byte_hi = value_i[2*CONST_W-1:CONST_W];

  imm_pattern #(.DATA_W(DATA_W), .CONST_W(CONST_W)) u_pat_lo (
    .byte_i (byte_lo), .kind_i (imm_pkg::KIND_LO),  .pat_o (pat_lo));
  imm_pattern #(.DATA_W(DATA_W), .CONST_W(CONST_W)) u_pat_hi (
    .byte_i (byte_hi), .kind_i (imm_pkg::KIND_HI),  .pat_o (pat_hi));
  imm_pattern #(.DATA_W(DATA_W), .CONST_W(CONST_W)) u_pat_all (
    .byte_i (byte_lo), .kind_i (imm_pkg::KIND_ALL), .pat_o (pat_all));

  always_comb begin
    field_o   = '0;
    invalid_o = 1'b0;
    if (rot_found)
      field_o = {imm_pkg::KIND_ROT, rot_sel, cand[rot_sel]};
    else if (mode_i == imm_pkg::MODE_EXT && value_i == pat_lo)
      field_o = {imm_pkg::KIND_LO, {ROT_W{1'b0}}, byte_lo};
    else if (mode_i == imm_pkg::MODE_EXT && value_i == pat_hi)
      field_o = {imm_pkg::KIND_HI, {ROT_W{1'b0}}, byte_hi};
    else if (mode_i == imm_pkg::MODE_EXT && value_i == pat_all)
      field_o = {imm_pkg::KIND_ALL, {ROT_W{1'b0}}, byte_lo};
    else
      invalid_o = 1'b1;
  end
endmodule

// File: rtl/imm_rsp_stage.sv
module imm_rsp_stage #(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               ready_i,
  input  logic [DATA_W-1:0]  value_i,
  input  logic               carry_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic               invalid_i,
  output logic               free_o,
  output logic               valid_o,
  output logic [DATA_W-1:0]  value_o,
  output logic               carry_o,
  output logic [FIELD_W-1:0] field_o,
  output logic               invalid_o
);
  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      value_o   <= '0;
      carry_o   <= 1'b0;
      field_o   <= '0;
      invalid_o <= 1'b0;
    end else if (load_i) begin
      valid_o   <= 1'b1;
      value_o   <= value_i;
      carry_o   <= carry_i;
      field_o   <= field_i;
      invalid_o <= invalid_i;
    end else if (ready_i) begin
      valid_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/imm_const_unit.sv
module imm_const_unit #(
  parameter int DATA_W  = 32,
  parameter int CONST_W = 8,
  parameter int ROT_W   = 4,
  localparam int FIELD_W = CONST_W + ROT_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               op_i,
  input  logic               mode_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic [DATA_W-1:0]  value_i,
  input  logic               carry_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [DATA_W-1:0]  rsp_value_o,
  output logic               rsp_carry_o,
  output logic [FIELD_W-1:0] rsp_field_o,
  output logic               rsp_invalid_o
);
  imm_pkg::op_e       op;
  imm_pkg::mode_e     mode;
  logic [DATA_W-1:0]  exp_value;
  logic               exp_carry;
  logic [FIELD_W-1:0] enc_field;
  logic               enc_invalid;
  logic [DATA_W-1:0]  d_value;
  logic               d_carry;
  logic [FIELD_W-1:0] d_field;
  logic               d_invalid;
  logic               accept;

  assign op   = imm_pkg::op_e'(op_i);
  assign mode = imm_pkg::mode_e'(mode_i);

  imm_expand #(.DATA_W(DATA_W), .CONST_W(CONST_W), .ROT_W(ROT_W)) u_expand (
    .mode_i  (mode),
    .field_i (field_i),
    .carry_i (carry_i),
    .value_o (exp_value),
    .carry_o (exp_carry)
  );

  imm_encode #(.DATA_W(DATA_W), .CONST_W(CONST_W), .ROT_W(ROT_W)) u_encode (
    .mode_i    (mode),
    .value_i   (value_i),
    .field_o   (enc_field),
    .invalid_o (enc_invalid)
  );

  always_comb begin
    if (op == imm_pkg::OP_EXPAND) begin
      d_value = exp_value; d_carry = exp_carry;
      d_field = '0;        d_invalid = 1'b0;
    end else begin
      d_value = '0;        d_carry = 1'b0;
      d_field = enc_field; d_invalid = enc_invalid;
    end
  end

  assign accept = req_valid_i && req_ready_o;

  imm_rsp_stage #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_rsp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .ready_i   (rsp_ready_i),
    .value_i   (d_value),
    .carry_i   (d_carry),
    .field_i   (d_field),
    .invalid_i (d_invalid),
    .free_o    (req_ready_o),
    .valid_o   (rsp_valid_o),
    .value_o   (rsp_value_o),
    .carry_o   (rsp_carry_o),
    .field_o   (rsp_field_o),
    .invalid_o (rsp_invalid_o)
  );
endmodule

// File: rtl/imm_const_unit_chk.sv
module imm_const_unit_chk #(
  parameter int DATA_W  = 32,
  parameter int CONST_W = 8,
  parameter int ROT_W   = 4,
  localparam int FIELD_W = CONST_W + ROT_W + 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic               op_i,
  input logic               mode_i,
  input logic [FIELD_W-1:0] field_i,
  input logic               carry_i,
  input logic               rsp_valid_o,
  input logic               rsp_ready_i,
  input logic [DATA_W-1:0]  rsp_value_o,
  input logic               rsp_carry_o,
  input logic [FIELD_W-1:0] rsp_field_o,
  input logic               rsp_invalid_o
);
  logic accept, rot_zero;
  assign accept   = req_valid_i && req_ready_o;
  assign rot_zero = (field_i[CONST_W +: ROT_W] == '0);

  assert_zero_rot_value_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !op_i && !mode_i && rot_zero |=>
      rsp_value_o == DATA_W'($past(field_i[CONST_W-1:0])));

  assert_all_bytes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !op_i && mode_i && field_i[FIELD_W-1 -: 2] == 2'd3 |=>
      rsp_value_o[CONST_W-1:0] == $past(field_i[CONST_W-1:0]) &&
      rsp_value_o[DATA_W-1 -: CONST_W] == $past(field_i[CONST_W-1:0]));

  assert_carry_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !op_i && !mode_i && rot_zero |=> rsp_carry_o == $past(carry_i));

  assert_plain_form_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && op_i && !mode_i |=> rsp_field_o[FIELD_W-1 -: 2] == 2'd0);

  assert_invalid_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_invalid_o |-> rsp_field_o == '0);

  assert_accept_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> rsp_valid_o);

  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_value_o) &&
      $stable(rsp_carry_o) && $stable(rsp_field_o) && $stable(rsp_invalid_o));

  assert_expand_clean_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !op_i |=> !rsp_invalid_o && rsp_field_o == '0);
endmodule

bind imm_const_unit imm_const_unit_chk #(
  .DATA_W(DATA_W), .CONST_W(CONST_W), .ROT_W(ROT_W)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .op_i          (op_i),
  .mode_i        (mode_i),
  .field_i       (field_i),
  .carry_i       (carry_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_ready_i   (rsp_ready_i),
  .rsp_value_o   (rsp_value_o),
  .rsp_carry_o   (rsp_carry_o),
  .rsp_field_o   (rsp_field_o),
  .rsp_invalid_o (rsp_invalid_o)
);

// File: tb/test_imm_const_unit.sv
module test_imm_const_unit;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        req_valid, req_ready, op, mode, cin;
  logic [13:0] field;
  logic [31:0] value;
  logic        rsp_valid, rsp_ready, rsp_carry, rsp_invalid;
  logic [31:0] rsp_value;
  logic [13:0] rsp_field;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  imm_const_unit i_imm_const_unit (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .op_i(op), .mode_i(mode), .field_i(field), .value_i(value), .carry_i(cin),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_value_o(rsp_value),
    .rsp_carry_o(rsp_carry), .rsp_field_o(rsp_field), .rsp_invalid_o(rsp_invalid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rotr32(input logic [31:0] v, input int a);
    return (a == 0) ? v : ((v >> a) | (v << (32 - a)));
  endfunction

  task automatic issue(input logic o, input logic m, input logic [13:0] f,
                       input logic [31:0] v, input logic c);
    @(negedge clk);
    req_valid = 1'b1; op = o; mode = m; field = f; value = v; cin = c;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 response valid", {31'b0, rsp_valid}, 32'd1);
  endtask

  task automatic do_expand(input logic m, input logic [13:0] f, input logic c,
                           input logic [31:0] ev, input logic ec, input string tag);
    issue(1'b0, m, f, 32'hDEAD_BEEF, c);
    chk(tag, rsp_value, ev);
    chk("R4 carry", {31'b0, rsp_carry}, {31'b0, ec});
    chk("R10 expand field", {18'b0, rsp_field}, 32'd0);
    chk("R10 expand invalid", {31'b0, rsp_invalid}, 32'd0);
  endtask

  task automatic do_encode(input logic m, input logic [31:0] v, input logic [13:0] ef,
                           input logic ei, input string tag);
    issue(1'b1, m, 14'h3FFF, v, 1'b1);
    chk(tag, {18'b0, rsp_field}, {18'b0, ef});
    chk("R7 invalid flag", {31'b0, rsp_invalid}, {31'b0, ei});
    chk("R10 encode value", rsp_value, 32'd0);
    chk("R10 encode carry", {31'b0, rsp_carry}, 32'd0);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; req_valid = 1'b0; rsp_ready = 1'b1;
    op = 1'b0; mode = 1'b0; field = '0; value = '0; cin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 valid in reset", {31'b0, rsp_valid}, 32'd0);
    chk("R9 ready in reset", {31'b0, req_ready}, 32'd1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R9 valid after reset", {31'b0, rsp_valid}, 32'd0);
    chk("R9 ready after reset", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic t_plain_expand;
    do_expand(1'b0, 14'h0423, 1'b1, 32'h2300_0000, 1'b0, "R1 0x23 ror 8");
    do_expand(1'b0, 14'h3423, 1'b0, 32'h2300_0000, 1'b0, "R1 form bits ignored");
    do_expand(1'b0, 14'h01FF, 1'b0, 32'hC000_003F, 1'b1, "R1 wrap ror 2");
    do_expand(1'b0, 14'h0080, 1'b1, 32'h0000_0080, 1'b1, "R1 no rotate cin 1");
    do_expand(1'b0, 14'h0080, 1'b0, 32'h0000_0080, 1'b0, "R1 no rotate cin 0");
  endtask

  task automatic t_ext_expand;
    do_expand(1'b1, 14'h0423, 1'b0, 32'h2300_0000, 1'b0, "R2 ext rotate");
    do_expand(1'b1, 14'h10A5, 1'b1, 32'h00A5_00A5, 1'b1, "R3 low bytes");
    do_expand(1'b1, 14'h2FA5, 1'b0, 32'hA500_A500, 1'b0, "R3 high bytes");
    do_expand(1'b1, 14'h35A5, 1'b1, 32'hA5A5_A5A5, 1'b1, "R3 all bytes");
  endtask

  task automatic t_sweep;
    for (int r = 0; r < 16; r++) begin
      logic [31:0] ev;
      logic [13:0] f;
      ev = rotr32(32'h81, 2 * r);
      f  = {2'b00, 4'(r), 8'h81};
      do_expand(1'b0, f, 1'b1, ev, (r != 0) ? ev[31] : 1'b1, "R1 sweep");
      do_expand(1'b1, f, 1'b0, ev, (r != 0) ? ev[31] : 1'b0, "R2 sweep");
      do_encode(1'b0, ev, f, 1'b0, "R5 sweep");
      do_encode(1'b1, ev, f, 1'b0, "R6 sweep");
    end
  endtask

  task automatic t_encode;
    do_encode(1'b0, 32'h2300_0000, 14'h0423, 1'b0, "R5 0x23000000");
    do_encode(1'b0, 32'h0000_0004, 14'h0004, 1'b0, "R5 smallest of several");
    do_encode(1'b0, 32'h0000_0100, 14'h0C01, 1'b0, "R5 count 12");
    do_encode(1'b0, 32'h0000_0000, 14'h0000, 1'b0, "R5 zero");
    do_encode(1'b0, 32'h0000_03FF, 14'h0000, 1'b1, "R7 plain 0x3FF");
    do_encode(1'b0, 32'hA5A5_A5A5, 14'h0000, 1'b1, "R7 plain replicated");
    do_encode(1'b1, 32'h0000_03FF, 14'h0000, 1'b1, "R7 ext 0x3FF");
    do_encode(1'b1, 32'h2300_0000, 14'h0423, 1'b0, "R6 rotate preferred");
    do_encode(1'b1, 32'h00A5_00A5, 14'h10A5, 1'b0, "R6 low bytes");
    do_encode(1'b1, 32'hA500_A500, 14'h20A5, 1'b0, "R6 high bytes");
    do_encode(1'b1, 32'hA5A5_A5A5, 14'h30A5, 1'b0, "R6 all bytes");
    do_encode(1'b1, 32'hFFFF_FFFF, 14'h30FF, 1'b0, "R6 all ones");
  endtask

  task automatic t_stall;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; op = 1'b0; mode = 1'b0; field = 14'h0423; value = '0; cin = 1'b0;
    @(negedge clk);
    chk("R8 stall valid", {31'b0, rsp_valid}, 32'd1);
    chk("R8 stall not ready", {31'b0, req_ready}, 32'd0);
    op = 1'b1; value = 32'h0000_03FF;
    @(negedge clk);
    chk("R8 held value", rsp_value, 32'h2300_0000);
    chk("R8 held field", {18'b0, rsp_field}, 32'd0);
    chk("R8 held valid", {31'b0, rsp_valid}, 32'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 queued taken", {31'b0, rsp_invalid}, 32'd1);
    chk("R8 queued value", rsp_value, 32'd0);
    @(negedge clk);
    chk("R8 drained", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_plain_expand();
    t_ext_expand();
    t_encode();
    t_sweep();
    t_stall();
    done = 1'b1;
    finish_sim();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual hang expected completion");
      finish_sim();
    end
  end
endmodule